// File: doc/BRIEF.md
# Block Pattern Generator and Verifier

This block drives a stream of 128-bit test words into a write-side FIFO and checks a 128-bit stream drained from a read-side FIFO against the same sequence, rebuilt locally. Software sets up the run before a start pulse: the direction, the pattern, the first block address (in 512-byte units) and the length (also in 512-byte units). The start pulse latches these values. A write run stops on its own after the programmed amount. Reads run freely whenever the read FIFO holds data.

Each 512-byte block is 32 beats of 128 bits. For the counting patterns and the pseudo-random pattern, the first beat of each block carries the block address as a 64-bit header, so a misplaced block is caught as well as corrupted data. On the first mismatch the block keeps the expected word, the received word and the byte address of the failing beat until the next start.

Top module: `pattgen_top`

## Requirements
- R1: While reset is held and right after it, `wr_en_o`, `busy_o` and `fail_o` are 0, `rd_en_o` is 0 while `rd_empty_i` is 1, and all three capture outputs are zero. Reset leaves the block in read mode.
- R2: A start pulse with `dir_wr_i`=1 and a nonzero length sets `busy_o` at the next clock edge. From then on, `wr_en_o` = `busy_o` and not `wr_afull_i`. A start pulse with length 0 leaves `busy_o` at 0 and issues no write.
- R3: A write run issues exactly length×32 beats, and `busy_o` falls at the same edge that takes the last beat.
- R4: No write beat is issued while `wr_afull_i` is 1. In a cycle where `start_i` is 1, neither `wr_en_o` nor `rd_en_o` is asserted.
- R5: Word lanes are 32-bit dwords, with dword k at bits [32k+31:32k]. The pattern select is 3 bits. With code 000 (increment), dword k of beat n since start holds the 32-bit value 4n+k. With code 001 (decrement), it holds the bitwise inverse of that value.
- R6: Code 010 gives all-zero words and code 011 gives all-one words, including the header positions. The reserved codes 101, 110 and 111 give all-zero words.
- R7: With code 100 (pseudo-random), each beat takes four successive steps of a 32-bit shift register. One step is s' = {s[30:0], s[30]^s[20]^s[0]}, which realises x^31+x^21+x+1. Dword k holds the value after step k+1, and the register keeps the fourth value for the next beat.
- R8: For codes 000, 001 and 100, the first beat of each block (beat index mod 32 = 0) carries the header. Dword 0 holds block address bits [31:0] and dword 1 holds the block address bits above 31, zero-extended. Dwords 2 and 3 keep the pattern.
- R9: The block address loads the programmed start block at the start pulse and increases by 1 after every 32 beats moved.
- R10: In read mode, `rd_en_o` is 1 in every cycle where the read FIFO is not empty and `start_i` is 0, including cycles after length×32 beats. Each read advances the beat and block counters.
- R11: The first read word that differs from the expected word sets `fail_o`. It also latches the expected word, the read word and the byte address block×512 + (beat mod 32)×16. Later mismatches change none of these.
- R12: A start pulse clears `fail_o`, the captures and the beat counter, and reseeds the shift register with 0x13579BDF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle run start; latches the setup inputs |
| dir_wr_i | input | 1 | 1 = generate into the write FIFO, 0 = verify from the read FIFO |
| patt_sel_i | input | 3 | Pattern code |
| start_blk_i | input | ADDR_W | First block address, 512-byte units |
| len_blk_i | input | LEN_W | Write run length, 512-byte units |
| wr_afull_i | input | 1 | Write FIFO almost full |
| wr_en_o | output | 1 | Write FIFO push |
| wr_data_o | output | 128 | Generated word |
| rd_empty_i | input | 1 | Read FIFO empty |
| rd_data_i | input | 128 | Head word of the read FIFO |
| rd_en_o | output | 1 | Read FIFO pop |
| busy_o | output | 1 | Write run active |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_exp_o | output | 128 | Expected word at first mismatch |
| fail_got_o | output | 128 | Read word at first mismatch |
| fail_addr_o | output | ADDR_W+9 | Byte address of first mismatch |

## Verification
Two pairs of events can meet in one cycle, and the bench provokes both. The first pair is the mismatch capture and the block-address increment: a corrupted word is placed on the 32nd beat of a block, and the captured byte address must carry the old block with offset 0x1F0, not the next block. The second pair is a start pulse and a non-empty read FIFO: the bench raises both together and checks that no pop occurs in that cycle and that one occurs in the next. A deliberate bad read made there then shows that a following start clears the captures.

// File: rtl/pattgen_pkg.sv
package pattgen_pkg;

    localparam int DW        = 32;
    localparam int LANES     = 4;
    localparam int BUS_W     = DW * LANES;
    localparam int BLK_SH    = 5;               // 32 beats per 512-byte block
    localparam int BYTE_SH   = 4;               // 16 bytes per beat
    localparam int HDR_LANES = 2;

    typedef enum logic [2:0] {
        PAT_INC  = 3'b000,
        PAT_DEC  = 3'b001,
        PAT_ZERO = 3'b010,
        PAT_ONE  = 3'b011,
        PAT_PRBS = 3'b100
    } pat_e;

    // one shift of the x^31 + x^21 + x + 1 register
    function automatic logic [DW-1:0] prbs_step(input logic [DW-1:0] s);
        return {s[DW-2:0], s[30] ^ s[20] ^ s[0]};
    endfunction

    function automatic logic has_header(input logic [2:0] sel);
        return (sel == PAT_INC) || (sel == PAT_DEC) || (sel == PAT_PRBS);
    endfunction

endpackage

// File: rtl/pattgen_prbs4.sv
module pattgen_prbs4
    import pattgen_pkg::*;
#(
    parameter logic [DW-1:0] SEED = 32'h1357_9BDF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reseed_i,
    input  logic                      adv_i,
    output logic [LANES-1:0][DW-1:0]  lane_o
);

    typedef struct packed {
        logic [DW-1:0] s;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] chain [0:LANES];

    assign chain[0] = st_q.s;

    // look-ahead: LANES chained steps in one cycle
    for (genvar g = 0; g < LANES; g++) begin : g_step
        assign chain[g+1] = prbs_step(chain[g]);
        assign lane_o[g]  = chain[g+1];
    end

    always_comb begin
        st_d = st_q;
        if (reseed_i) begin
            st_d.s = SEED;
        end else if (adv_i) begin
            st_d.s = chain[LANES];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{s: SEED};
        end else begin
            st_q <= st_d;
        end
    end

    AST_PRBS_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !reseed_i |=> st_q.s != '0); // R7

endmodule

// File: rtl/pattgen_word.sv
module pattgen_word
    import pattgen_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [2:0]                sel_i,
    input  logic [DW-1:0]             dword_base_i,
    input  logic                      hdr_beat_i,
    input  logic [ADDR_W-1:0]         blk_i,
    input  logic [LANES-1:0][DW-1:0]  prbs_i,
    output logic [BUS_W-1:0]          word_o
);

    logic [2*DW-1:0] hdr64;
    logic            hdr_on;

    assign hdr64  = (2*DW)'(blk_i);
    assign hdr_on = hdr_beat_i && has_header(sel_i);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DW-1:0] idx;
        logic [DW-1:0] body;

        assign idx = dword_base_i + DW'(g);

        always_comb begin
            case (sel_i)
                PAT_INC:  body = idx;
                PAT_DEC:  body = ~idx;
                PAT_ONE:  body = '1;
                PAT_PRBS: body = prbs_i[g];
                default:  body = '0;
            endcase
        end

        if (g < HDR_LANES) begin : g_hdr
            assign word_o[g*DW +: DW] = hdr_on ? hdr64[g*DW +: DW] : body;
        end else begin : g_plain
            assign word_o[g*DW +: DW] = body;
        end
    end

endmodule

// File: rtl/pattgen_ctrl.sv
module pattgen_ctrl
    import pattgen_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int LEN_W  = 16,
    localparam int CNT_W = LEN_W + BLK_SH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               dir_wr_i,
    input  logic [2:0]         sel_i,
    input  logic [ADDR_W-1:0]  start_blk_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               wr_afull_i,
    input  logic               rd_empty_i,
    output logic               wr_en_o,
    output logic               rd_en_o,
    output logic               adv_o,
    output logic               busy_o,
    output logic [2:0]         sel_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [ADDR_W-1:0]  blk_o
);

    typedef struct packed {
        logic               act;
        logic               dir;
        logic [2:0]         sel;
        logic [CNT_W-1:0]   end_cnt;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  blk;
    } st_t;

    st_t  st_d, st_q;
    logic wr_en, rd_en, last_beat, blk_wrap;

    assign wr_en     = st_q.act && !wr_afull_i && !start_i;
    assign rd_en     = !st_q.dir && !rd_empty_i && !start_i;
    assign last_beat = (st_q.cnt + 1'b1) == st_q.end_cnt;
    assign blk_wrap  = &st_q.cnt[BLK_SH-1:0];

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.act     = dir_wr_i && (len_i != '0);
            st_d.dir     = dir_wr_i;
            st_d.sel     = sel_i;
            st_d.end_cnt = {len_i, {BLK_SH{1'b0}}};
            st_d.cnt     = '0;
            st_d.blk     = start_blk_i;
        end else if (wr_en || rd_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (blk_wrap) begin
                st_d.blk = st_q.blk + 1'b1;
            end
            if (wr_en && last_beat) begin
                st_d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o = wr_en;
    assign rd_en_o = rd_en;
    assign adv_o   = wr_en || rd_en;
    assign busy_o  = st_q.act;
    assign sel_o   = st_q.sel;
    assign cnt_o   = st_q.cnt;
    assign blk_o   = st_q.blk;

    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && dir_wr_i && (len_i != '0) |=> busy_o); // R2
    AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (len_i == '0) |=> !busy_o); // R2
    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o && last_beat |=> !busy_o); // R3
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> st_q.cnt < st_q.end_cnt); // R3
    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en_o, rd_en_o})); // R4
    AST_BLK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o && blk_wrap |=> blk_o == $past(blk_o) + 1'b1); // R9

endmodule

// File: rtl/pattgen_chk.sv
module pattgen_chk
    import pattgen_pkg::*;
#(
    parameter int FA_W = 57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              cmp_en_i,
    input  logic [BUS_W-1:0]  exp_i,
    input  logic [BUS_W-1:0]  got_i,
    input  logic [FA_W-1:0]   addr_i,
    output logic              fail_o,
    output logic [BUS_W-1:0]  exp_o,
    output logic [BUS_W-1:0]  got_o,
    output logic [FA_W-1:0]   addr_o
);

    typedef struct packed {
        logic              fail;
        logic [BUS_W-1:0]  exp;
        logic [BUS_W-1:0]  got;
        logic [FA_W-1:0]   addr;
    } st_t;

    st_t  st_d, st_q;
    logic miss;

    assign miss = cmp_en_i && (got_i != exp_i);

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (miss && !st_q.fail) begin
            st_d.fail = 1'b1;
            st_d.exp  = exp_i;
            st_d.got  = got_i;
            st_d.addr = addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fail_o = st_q.fail;
    assign exp_o  = st_q.exp;
    assign got_o  = st_q.got;
    assign addr_o = st_q.addr;

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o && !clear_i |=> fail_o && $stable(addr_o) && $stable(got_o)); // R11
    AST_FAIL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        miss && !clear_i |=> fail_o); // R11
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !fail_o && (addr_o == '0)); // R12

endmodule

// File: rtl/pattgen_top.sv
module pattgen_top
    import pattgen_pkg::*;
#(
    parameter int              ADDR_W = 48,
    parameter int              LEN_W  = 16,
    parameter logic [DW-1:0]   SEED   = 32'h1357_9BDF,
    localparam int             CNT_W  = LEN_W + BLK_SH,
    localparam int             FA_W   = ADDR_W + BLK_SH + BYTE_SH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               dir_wr_i,
    input  logic [2:0]         patt_sel_i,
    input  logic [ADDR_W-1:0]  start_blk_i,
    input  logic [LEN_W-1:0]   len_blk_i,
    input  logic               wr_afull_i,
    output logic               wr_en_o,
    output logic [BUS_W-1:0]   wr_data_o,
    input  logic               rd_empty_i,
    input  logic [BUS_W-1:0]   rd_data_i,
    output logic               rd_en_o,
    output logic               busy_o,
    output logic               fail_o,
    output logic [BUS_W-1:0]   fail_exp_o,
    output logic [BUS_W-1:0]   fail_got_o,
    output logic [FA_W-1:0]    fail_addr_o
);

    logic                      adv;
    logic [2:0]                sel;
    logic [CNT_W-1:0]          cnt;
    logic [ADDR_W-1:0]         blk;
    logic [LANES-1:0][DW-1:0]  prbs;
    logic [BUS_W-1:0]          word;
    logic [DW-1:0]             dword_base;
    logic [FA_W-1:0]           beat_addr;
    logic                      rd_en;

    assign dword_base = DW'({cnt, 2'b00});
    assign beat_addr  = {blk, cnt[BLK_SH-1:0], {BYTE_SH{1'b0}}};

    pattgen_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dir_wr_i    (dir_wr_i),
        .sel_i       (patt_sel_i),
        .start_blk_i (start_blk_i),
        .len_i       (len_blk_i),
        .wr_afull_i  (wr_afull_i),
        .rd_empty_i  (rd_empty_i),
        .wr_en_o     (wr_en_o),
        .rd_en_o     (rd_en),
        .adv_o       (adv),
        .busy_o      (busy_o),
        .sel_o       (sel),
        .cnt_o       (cnt),
        .blk_o       (blk)
    );

    pattgen_prbs4 #(.SEED(SEED)) u_prbs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reseed_i (start_i),
        .adv_i    (adv),
        .lane_o   (prbs)
    );

    pattgen_word #(.ADDR_W(ADDR_W)) u_word (
        .sel_i        (sel),
        .dword_base_i (dword_base),
        .hdr_beat_i   (cnt[BLK_SH-1:0] == '0),
        .blk_i        (blk),
        .prbs_i       (prbs),
        .word_o       (word)
    );

    pattgen_chk #(.FA_W(FA_W)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start_i),
        .cmp_en_i (rd_en),
        .exp_i    (word),
        .got_i    (rd_data_i),
        .addr_i   (beat_addr),
        .fail_o   (fail_o),
        .exp_o    (fail_exp_o),
        .got_o    (fail_got_o),
        .addr_o   (fail_addr_o)
    );

    assign wr_data_o = word;
    assign rd_en_o   = rd_en;

    AST_POP_WHEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> !rd_empty_i && !busy_o); // R10

endmodule

// File: tb/tb_pattgen_top.sv
module tb_pattgen_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SEED = 32'h1357_9BDF;
    localparam int NV = 10;

    typedef struct packed {
        logic        wr;
        logic [2:0]  sel;
        logic [47:0] blk;
        logic [15:0] len;
        logic [7:0]  bad;     // 8'hFF: no corrupted read
        logic [1:0]  stall;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'b000, 48'h10,             16'd2, 8'hFF, 2'd1},
        '{1'b1, 3'b001, 48'h0001_2345_6789, 16'd1, 8'hFF, 2'd2},
        '{1'b1, 3'b010, 48'h5,              16'd1, 8'hFF, 2'd0},
        '{1'b1, 3'b011, 48'h7,              16'd1, 8'hFF, 2'd1},
        '{1'b1, 3'b100, 48'hFFFF_FFFF,      16'd2, 8'hFF, 2'd2},
        '{1'b1, 3'b110, 48'h4,              16'd1, 8'hFF, 2'd0},
        '{1'b0, 3'b000, 48'h3,              16'd2, 8'd40, 2'd1},
        '{1'b0, 3'b100, 48'h9,              16'd1, 8'd31, 2'd2},
        '{1'b0, 3'b001, 48'h0,              16'd1, 8'hFF, 2'd0},
        '{1'b0, 3'b011, 48'h2,              16'd1, 8'd0,  2'd1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         dir_wr = 1'b0;
    logic [2:0]   sel = '0;
    logic [47:0]  start_blk = '0;
    logic [15:0]  len = '0;
    logic         wr_afull = 1'b0;
    logic         wr_en;
    logic [127:0] wr_data;
    logic         rd_empty = 1'b1;
    logic [127:0] rd_data = '0;
    logic         rd_en;
    logic         busy;
    logic         fail;
    logic [127:0] fail_exp;
    logic [127:0] fail_got;
    logic [56:0]  fail_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pattgen_top dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dir_wr_i(dir_wr),
        .patt_sel_i(sel), .start_blk_i(start_blk), .len_blk_i(len),
        .wr_afull_i(wr_afull), .wr_en_o(wr_en), .wr_data_o(wr_data),
        .rd_empty_i(rd_empty), .rd_data_i(rd_data), .rd_en_o(rd_en),
        .busy_o(busy), .fail_o(fail), .fail_exp_o(fail_exp),
        .fail_got_o(fail_got), .fail_addr_o(fail_addr)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_step(input logic [31:0] s);
        return {s[30:0], s[30] ^ s[20] ^ s[0]};
    endfunction

    function automatic logic [31:0] m_step4(input logic [31:0] s);
        logic [31:0] t = s;
        for (int i = 0; i < 4; i++) t = m_step(t);
        return t;
    endfunction

    // expected word for beat n since start (R5..R9)
    function automatic logic [127:0] m_word(input logic [2:0] ps, input int n,
                                            input logic [47:0] b0, input logic [31:0] s);
        logic [127:0] w;
        logic [31:0]  t = s;
        logic [63:0]  hdr = 64'(b0 + 48'(n / 32));
        for (int k = 0; k < 4; k++) begin
            logic [31:0] idx = 32'(4 * n + k);
            logic [31:0] v;
            t = m_step(t);
            case (ps)
                3'b000: v = idx;
                3'b001: v = ~idx;
                3'b011: v = '1;
                3'b100: v = t;
                default: v = '0;
            endcase
            if (k < 2 && (n % 32) == 0 && (ps == 3'b000 || ps == 3'b001 || ps == 3'b100))
                v = hdr[32*k +: 32];
            w[32*k +: 32] = v;
        end
        return w;
    endfunction

    function automatic logic stall_on(input logic [1:0] m, input int c);
        case (m)
            2'd1: return (c % 4) == 1;
            2'd2: return (c % 7) >= 4;
            default: return 1'b0;
        endcase
    endfunction

    task automatic pulse_start(input vec_t v);
        @(negedge clk);
        dir_wr = v.wr; sel = v.sel; start_blk = v.blk; len = v.len;
        rd_empty = 1'b1; wr_afull = 1'b0; start = 1'b1;
        #1;
        check(!wr_en && !rd_en, "R4 no enable in start cycle", {wr_en, rd_en}, 0);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_write(input vec_t v);
        int n = 0, c = 0, bad_n = -1, last_c = -1, low_c = -1;
        bit afull_hit = 0;
        logic [31:0]  s = SEED;
        logic [127:0] bad_a = '0, bad_e = '0;
        pulse_start(v);
        #1;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        while (c < 5000) begin
            if (c > 0) @(negedge clk);
            wr_afull = stall_on(v.stall, c);
            #1;
            if (!busy) begin low_c = c; break; end
            if (wr_en) begin
                logic [127:0] e = m_word(v.sel, n, v.blk, s);
                if (wr_afull) afull_hit = 1;
                if (wr_data != e && bad_n < 0) begin bad_n = n; bad_a = wr_data; bad_e = e; end
                n++; s = m_step4(s); last_c = c;
            end
            c++;
        end
        wr_afull = 1'b0;
        check(!afull_hit, "R4 no write while almost full", afull_hit, 0);
        check(bad_n < 0, $sformatf("R5/R6/R7/R8/R9 write word sel=%b beat %0d", v.sel, bad_n),
              bad_a, bad_e);
        check(n == 32 * int'(v.len), "R3 write beat total", n, 32 * v.len);
        check(low_c == last_c + 1, "R3 busy falls with last beat", low_c, last_c + 1);
    endtask

    task automatic run_read(input vec_t v);
        int total = 32 * int'(v.len) + 3;
        int n = 0, c = 0;
        int bad = (v.bad == 8'hFF) ? -10 : int'(v.bad);
        logic [31:0]  s = SEED;
        logic [127:0] e_at = '0, g_at = '0;
        pulse_start(v);
        while (n < total && c < 5000) begin
            logic [127:0] w;
            if (c > 0) @(negedge clk);
            rd_empty = stall_on(v.stall, c);
            w = m_word(v.sel, n, v.blk, s);
            if (n == bad) begin e_at = w; g_at = w ^ (128'h1 << (n % 128)); end
            if (n == bad || n == bad + 2) w = w ^ (128'h1 << (n % 128));
            rd_data = w;
            #1;
            if (rd_en) begin n++; s = m_step4(s); end
            c++;
        end
        @(negedge clk);
        rd_empty = 1'b1;
        #1;
        check(n == total, "R10 reads continue past length", n, total);
        if (bad < 0) begin
            check(fail == 1'b0, "R11 clean read stream", fail, 0);
        end else begin
            logic [56:0] a = {v.blk + 48'(bad / 32), 5'(bad % 32), 4'b0};
            check(fail == 1'b1, "R11 mismatch flagged", fail, 1);
            check(fail_exp == e_at, "R11 captured expected word", fail_exp, e_at);
            check(fail_got == g_at, "R11 captured read word (first only)", fail_got, g_at);
            check(fail_addr == a, "R11 captured byte address", fail_addr, a);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired (R1..R12 incomplete) actual=hung expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        check(!wr_en && !busy && !fail && !rd_en, "R1 outputs in reset",
              {wr_en, busy, fail, rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!busy && !fail && fail_addr == '0 && fail_got == '0 && fail_exp == '0,
              "R1 state after reset", {busy, fail, fail_addr}, 0);

        // stimulus table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) run_write(VECS[i]);
            else run_read(VECS[i]);
        end

        // R2: zero length start stays idle
        @(negedge clk);
        dir_wr = 1'b1; len = '0; sel = 3'b000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(!busy && !wr_en, "R2 zero length idle", {busy, wr_en}, 0);

        // R4/R10: start coinciding with a non-empty read FIFO
        @(negedge clk);
        dir_wr = 1'b0; len = 16'd1; sel = 3'b000; start_blk = 48'h20;
        rd_data = 128'hDEAD; rd_empty = 1'b0; start = 1'b1;
        #1;
        check(rd_en == 1'b0, "R4 pop held off during start", rd_en, 0);
        @(negedge clk);
        start = 1'b0;
        #1;
        check(rd_en == 1'b1, "R10 pop when not empty", rd_en, 1);
        @(negedge clk);
        rd_empty = 1'b1;
        #1;
        check(fail == 1'b1 && fail_got == 128'hDEAD, "R11 bad first word caught", fail_got,
              128'hDEAD);

        // R12: start clears captures
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(!fail && fail_got == '0 && fail_addr == '0, "R12 start clears captures",
              {fail, fail_got}, 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule